// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block sits beside a real-time clock core and watches its minute, hour, day-of-month and weekday outputs. Software programs four alarm fields through a small register bus. Each field carries its own "ignore" bit, so one alarm can be made to repeat every hour, every day or on chosen weekdays. The weekday field is a seven-bit mask, which lets several weekdays trigger the same alarm.

The comparison runs once per minute, on a one-cycle tick from the clock core. When every field that is not ignored agrees with the clock, a sticky alarm flag is set. It stays set until software writes a zero to it. An active-low interrupt line is driven low while the flag is set and the alarm interrupt enable input is high.

Top module: `cal_alarm_irq`

## Requirements
- R1: After a synchronous active-low reset, all four alarm registers read 0x00, the flag is 0 and `irq_n` is 1.
- R2: A write with `bus_wr` high stores `bus_wdata` whole into one alarm register, chosen by `bus_addr`: 0 is minute, 1 is hour, 2 is day of month, 3 is weekday mask. `bus_rdata` returns the register that `bus_addr` selects, in the same cycle.
- R3: When bit 7 of a BCD field register is 0, that field matches only when the bits under compare are equal. For minute these are bits 6..0; for hour and day they are bits 5..0. When bit 7 is 1, the field always matches. Clock bits above the compared range are ignored.
- R4: When bit 7 of the weekday register is 0, the weekday field matches when register bit `cur_wday` is set. Index 0 is Sunday, 1 Monday, 2 Tuesday, 3 Wednesday, 4 Thursday, 5 Friday and 6 Saturday. Several bits may be set at once. `cur_wday` = 7 never matches.
- R5: The flag becomes 1 in the cycle after a `min_tick` at which all four fields match and the previous tick did not match. Without a tick the flag never sets.
- R6: A match that continues over consecutive ticks sets the flag only once. If all four fields have bit 7 set, every tick sets the flag.
- R7: Writing address 4 with bit 0 = 0 clears the flag. Writing bit 0 = 1 has no effect. When a setting tick and a clear write fall in the same cycle, the flag ends set.
- R8: `irq_n` is 0 exactly when the flag is 1 and `irq_en` is 1. It returns to 1 as soon as either one drops.
- R9: The flag sets on a match whatever the value of `irq_en`.
- R10: A read of address 4 returns the flag in bit 0 and zeros above it. Addresses 5 to 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| min_tick | input | 1 | One-cycle pulse when the clock fields take a new minute |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday index, 0 = Sunday |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions check on every cycle that the interrupt line agrees with the flag and the enable in both directions. They also check that the flag rises only after a matching tick and falls only after a clear write, that it holds when there is neither, and that a tick with every field ignored always leaves the flag set. Only the bench's scenarios can show that each field honours its compare width and its ignore bit, and that the weekday mask decodes the right day. The same goes for a continued match setting the flag just once, a set beating a clear in the same cycle, and the read map returning the right bytes. For these the bench uses a behavioural reference model and literal expected values.

// File: rtl/cal_alarm_pkg.sv
// Package: shared constants and helpers for the calendar alarm block.
// Assumes BCD clock fields of at most eight bits and a three-bit weekday index.
package cal_alarm_pkg;
    localparam int DATA_W      = 8;
    localparam int NUM_FIELDS  = 4;
    localparam int NUM_BCD     = 3;
    localparam int ADDR_W      = 3;
    localparam int WDAY_W      = 3;
    localparam int DAYS        = 7;
    localparam int IGNORE_BIT  = 7;
    localparam int FLD_MIN     = 0;
    localparam int FLD_HOUR    = 1;
    localparam int FLD_DAY     = 2;
    localparam int FLD_WDAY    = 3;
    localparam int ADDR_CTRL   = 4;

    typedef logic [DATA_W-1:0] areg_t;

    // Bits of a BCD field that take part in the comparison.
    function automatic areg_t bcd_cmp_mask(input int fld);
        areg_t m;
        case (fld)
            FLD_MIN: m = areg_t'(8'h7f);
            default: m = areg_t'(8'h3f);
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
// Module: alarm register file with bus write, readback and a flag-clear strobe.
// Assumes one write per cycle; read data is combinational on bus_addr.
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int D_W    = DATA_W,
    parameter int N_FLD  = NUM_FIELDS,
    parameter int A_W    = ADDR_W,
    parameter int CTRL_A = ADDR_CTRL
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [A_W-1:0]            addr,
    input  logic [D_W-1:0]            wdata,
    input  logic                      flag,
    output logic [N_FLD-1:0][D_W-1:0] regs,
    output logic                      clr_req,
    output logic [D_W-1:0]            rdata
);
    localparam logic [A_W-1:0] CTRL_SEL = A_W'(CTRL_A);

    for (genvar g = 0; g < N_FLD; g++) begin : g_reg
        localparam logic [A_W-1:0] SEL = A_W'(g);
        // Hold one alarm field; load it on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr && addr == SEL) begin
                regs[g] <= wdata;
            end
        end
    end

    // Request a flag clear when the control address is written with bit 0 low.
    always_comb begin
        clr_req = wr && (addr == CTRL_SEL) && !wdata[0];
    end

    // Select read data for the addressed register or the flag.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_FLD; i++) begin
            if (addr == A_W'(i)) begin
                rdata = regs[i];
            end
        end
        if (addr == CTRL_SEL) begin
            rdata = {{(D_W-1){1'b0}}, flag};
        end
    end
endmodule

// File: rtl/cal_alarm_cmp.sv
// Module: compares the alarm fields with the running clock fields.
// Assumes the BCD fields come in the order minute, hour, day and the weekday
// register is the last field; full_match is combinational.
module cal_alarm_cmp
    import cal_alarm_pkg::*;
#(
    parameter int D_W    = DATA_W,
    parameter int N_FLD  = NUM_FIELDS,
    parameter int N_BCD  = NUM_BCD,
    parameter int WD_W   = WDAY_W,
    parameter int N_DAYS = DAYS,
    parameter int IGN    = IGNORE_BIT
) (
    input  logic [N_FLD-1:0][D_W-1:0] regs,
    input  logic [N_BCD-1:0][D_W-1:0] cur_bcd,
    input  logic [WD_W-1:0]           cur_wday,
    output logic                      full_match,
    output logic                      all_masked
);
    localparam int WD_FLD = N_FLD - 1;

    logic [N_FLD-1:0] fld_hit;
    logic [N_FLD-1:0] fld_ign;

    for (genvar g = 0; g < N_BCD; g++) begin : g_bcd
        localparam logic [D_W-1:0] CMASK = D_W'(bcd_cmp_mask(g));
        // Match one BCD field under its compare mask or its ignore bit.
        always_comb begin
            fld_ign[g] = regs[g][IGN];
            fld_hit[g] = fld_ign[g] || ((regs[g] & CMASK) == (cur_bcd[g] & CMASK));
        end
    end

    // Match the weekday field by picking the mask bit of the current day.
    always_comb begin
        logic day_bit;
        day_bit = 1'b0;
        for (int i = 0; i < N_DAYS; i++) begin
            if (cur_wday == WD_W'(i)) begin
                day_bit = regs[WD_FLD][i];
            end
        end
        fld_ign[WD_FLD] = regs[WD_FLD][IGN];
        fld_hit[WD_FLD] = fld_ign[WD_FLD] || day_bit;
    end

    // Combine the per-field results.
    always_comb begin
        full_match = &fld_hit;
        all_masked = &fld_ign;
    end
endmodule

// File: rtl/cal_alarm_flag.sv
// Module: sticky alarm flag with match edge detection, and the interrupt line.
// Assumes min_tick is a single-cycle pulse; a set beats a clear in one cycle.
module cal_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic min_tick,
    input  logic full_match,
    input  logic all_masked,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq_n
);
    logic prev_match;
    logic set_ev;

    // Remember whether the last tick matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_match <= 1'b0;
        end else if (min_tick) begin
            prev_match <= full_match;
        end
    end

    // Set on a new match, or on every tick when every field is ignored.
    always_comb begin
        set_ev = min_tick && full_match && (!prev_match || all_masked);
    end

    // Update the sticky flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Drive the active-low interrupt from the flag and the enable.
    always_comb begin
        irq_n = !(flag && irq_en);
    end
endmodule

// File: rtl/cal_alarm_irq.sv
// Module: calendar alarm top. Joins the register file, the field comparator
// and the flag logic. Assumes the clock fields are stable while min_tick is high.
module cal_alarm_irq
    import cal_alarm_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int A_W   = ADDR_W,
    parameter int WD_W  = WDAY_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           min_tick,
    input  logic [D_W-1:0] cur_min,
    input  logic [D_W-1:0] cur_hour,
    input  logic [D_W-1:0] cur_day,
    input  logic [WD_W-1:0] cur_wday,
    input  logic           bus_wr,
    input  logic [A_W-1:0] bus_addr,
    input  logic [D_W-1:0] bus_wdata,
    output logic [D_W-1:0] bus_rdata,
    input  logic           irq_en,
    output logic           alarm_flag,
    output logic           irq_n
);
    localparam int N_FLD = NUM_FIELDS;
    localparam int N_BCD = NUM_BCD;

    logic [N_FLD-1:0][D_W-1:0] regs;
    logic [N_BCD-1:0][D_W-1:0] cur_bcd;
    logic                      clr_req;
    logic                      full_match;
    logic                      all_masked;

    // Gather the BCD clock fields in register order.
    always_comb begin
        cur_bcd[FLD_MIN]  = cur_min;
        cur_bcd[FLD_HOUR] = cur_hour;
        cur_bcd[FLD_DAY]  = cur_day;
    end

    cal_alarm_regs #(
        .D_W(D_W), .N_FLD(N_FLD), .A_W(A_W), .CTRL_A(ADDR_CTRL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .flag(alarm_flag), .regs(regs),
        .clr_req(clr_req), .rdata(bus_rdata)
    );

    cal_alarm_cmp #(
        .D_W(D_W), .N_FLD(N_FLD), .N_BCD(N_BCD), .WD_W(WD_W),
        .N_DAYS(DAYS), .IGN(IGNORE_BIT)
    ) u_cmp (
        .regs(regs), .cur_bcd(cur_bcd), .cur_wday(cur_wday),
        .full_match(full_match), .all_masked(all_masked)
    );

    cal_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick),
        .full_match(full_match), .all_masked(all_masked),
        .clr_req(clr_req), .irq_en(irq_en),
        .flag(alarm_flag), .irq_n(irq_n)
    );
endmodule

// File: rtl/cal_alarm_irq_chk.sv
// Module: assertion checker for cal_alarm_irq, attached with bind.
// Assumes reset is held low from time zero.
module cal_alarm_irq_chk #(
    parameter int A_W = 3,
    parameter int D_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           min_tick,
    input logic           bus_wr,
    input logic [A_W-1:0] bus_addr,
    input logic [D_W-1:0] bus_wdata,
    input logic           irq_en,
    input logic           alarm_flag,
    input logic           irq_n,
    input logic           full_match,
    input logic           all_masked
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == A_W'(4));

    // R8: the line is low only when the flag and the enable are both high
    p_irq_low_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (alarm_flag && irq_en));
    // R8: an armed flag always pulls the line low
    p_irq_armed_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && irq_en) |-> !irq_n);
    // R5: the flag rises only after a matching tick
    p_set_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(min_tick) && $past(full_match)));
    // R7: the flag falls only after a clearing write
    p_clear_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(ctrl_wr && !bus_wdata[0]));
    // R7: without a tick or a control write the flag holds
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!min_tick && !ctrl_wr) |=> $stable(alarm_flag));
    // R6: with every field ignored each tick leaves the flag set
    p_masked_every_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && all_masked) |=> alarm_flag);
endmodule

bind cal_alarm_irq cal_alarm_irq_chk #(.A_W(A_W), .D_W(D_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_en(irq_en),
    .alarm_flag(alarm_flag), .irq_n(irq_n),
    .full_match(full_match), .all_masked(all_masked)
);

// File: tb/cal_alarm_irq_tb.sv
// Bench: directed scenarios plus a behavioural reference model compared every clock.
module cal_alarm_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_tick = 1'b0;
    logic [7:0] tb_min = 8'h00, tb_hour = 8'h00, tb_day = 8'h00;
    logic [2:0] tb_wday = 3'd0;
    logic       tb_wr = 1'b0;
    logic [2:0] tb_addr = 3'd0;
    logic [7:0] tb_wdata = 8'h00;
    logic       tb_en = 1'b0;
    logic [7:0] rdata;
    logic       flag, irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_reg[4];
    bit m_flag = 0;
    bit m_prev = 0;

    always #2 clk = ~clk;

    cal_alarm_irq dut_i (
        .clk(clk), .rst_n(rst_n), .min_tick(tb_tick),
        .cur_min(tb_min), .cur_hour(tb_hour), .cur_day(tb_day), .cur_wday(tb_wday),
        .bus_wr(tb_wr), .bus_addr(tb_addr), .bus_wdata(tb_wdata), .bus_rdata(rdata),
        .irq_en(tb_en), .alarm_flag(flag), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_match();
        bit ok = 1;
        int cur[3];
        int msk[3];
        cur[0] = tb_min; cur[1] = tb_hour; cur[2] = tb_day;
        msk[0] = 'h7f; msk[1] = 'h3f; msk[2] = 'h3f;
        for (int i = 0; i < 3; i++)
            if (m_reg[i] < 128 && (m_reg[i] % (msk[i] + 1)) != (cur[i] % (msk[i] + 1))) ok = 0;
        if (m_reg[3] < 128) begin
            if (tb_wday == 7) ok = 0;
            else if (((m_reg[3] >> tb_wday) & 1) == 0) ok = 0;
        end
        return ok;
    endfunction

    // advance the reference model by one clock using the driven inputs
    task automatic model_step();
        bit mt, allm, set;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
            m_flag = 0; m_prev = 0;
            return;
        end
        mt = model_match();
        allm = (m_reg[0] >= 128) && (m_reg[1] >= 128) && (m_reg[2] >= 128) && (m_reg[3] >= 128);
        set = tb_tick && mt && (!m_prev || allm);
        if (tb_tick) m_prev = mt;
        if (set) m_flag = 1;
        else if (tb_wr && tb_addr == 4 && tb_wdata[0] == 0) m_flag = 0;
        if (tb_wr && tb_addr < 4) m_reg[tb_addr] = tb_wdata;
    endtask

    function automatic int model_rd();
        if (tb_addr < 4) return m_reg[tb_addr];
        if (tb_addr == 4) return m_flag;
        return 0;
    endfunction

    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        if (rst_n) begin
            chk("R5 flag vs model", flag, m_flag);
            chk("R8 irq_n vs model", irq_n, !(m_flag && tb_en));
            chk("R2 rdata vs model", rdata, model_rd());
        end
    endtask

    task automatic wr(input int a, input int d);
        tb_wr = 1; tb_addr = 3'(a); tb_wdata = 8'(d);
        cycle();
        tb_wr = 0;
    endtask

    task automatic rd_check(input string tag, input int a, input int exp);
        tb_addr = 3'(a);
        cycle();
        chk(tag, rdata, exp);
    endtask

    task automatic tick(input int mn, input int hr, input int dy, input int wd);
        tb_min = 8'(mn); tb_hour = 8'(hr); tb_day = 8'(dy); tb_wday = 3'(wd);
        tb_tick = 1;
        cycle();
        tb_tick = 0;
    endtask

    task automatic clear_flag();
        wr(4, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R1 reset state
        chk("R1 flag", flag, 0);
        chk("R1 irq_n", irq_n, 1);
        for (int a = 0; a < 4; a++) rd_check("R1 reg", a, 0);

        // R2/R3 minute-only alarm at :30
        wr(0, 'h30); wr(1, 'h80); wr(2, 'h80); wr(3, 'h80);
        rd_check("R2 minute reg", 0, 'h30);
        rd_check("R2 hour reg keeps bit7", 1, 'h80);
        tick('h29, 'h10, 'h05, 2);
        chk("R3 minute mismatch", flag, 0);
        tick('h30, 'h10, 'h05, 2);
        chk("R5 set on match", flag, 1);
        chk("R9 flag with enable low, irq_n", irq_n, 1);
        tb_en = 1; cycle();
        chk("R8 irq_n armed", irq_n, 0);
        clear_flag();
        chk("R7 cleared", flag, 0);
        chk("R8 irq_n released", irq_n, 1);
        tick('h31, 'h10, 'h05, 2);
        tick('hB0, 'h10, 'h05, 2);
        chk("R3 clock bit7 ignored", flag, 1);
        clear_flag();
        tb_en = 0; cycle();

        // R6 hour-only alarm at 07
        wr(0, 'h80); wr(1, 'h07);
        tick('h00, 'h06, 'h05, 2);
        chk("R3 hour mismatch", flag, 0);
        tick('h00, 'h07, 'h05, 2);
        chk("R5 hour match", flag, 1);
        clear_flag();
        tick('h01, 'h07, 'h05, 2);
        chk("R6 continued match no reset", flag, 0);
        tick('h00, 'h08, 'h05, 2);
        tick('h00, 'h07, 'h05, 2);
        chk("R6 new match sets", flag, 1);
        clear_flag();

        // R4 weekday mask Monday and Friday
        wr(1, 'h80); wr(3, 'h22);
        tick('h00, 'h00, 'h01, 0);
        chk("R4 Sunday no", flag, 0);
        tick('h01, 'h00, 'h01, 1);
        chk("R4 Monday yes", flag, 1);
        clear_flag();
        tick('h02, 'h00, 'h01, 2);
        chk("R4 Tuesday no", flag, 0);
        tick('h03, 'h00, 'h01, 5);
        chk("R4 Friday yes", flag, 1);
        clear_flag();
        wr(3, 'h7f);
        tick('h04, 'h00, 'h01, 7);
        chk("R4 index 7 never", flag, 0);
        tick('h05, 'h00, 'h01, 6);
        chk("R4 Saturday yes", flag, 1);
        clear_flag();

        // R3 day field
        wr(3, 'h80); wr(2, 'h15);
        tick('h00, 'h00, 'h14, 3);
        chk("R3 day mismatch", flag, 0);
        tick('h00, 'h00, 'h15, 3);
        chk("R3 day match", flag, 1);
        clear_flag();

        // R6 all fields ignored
        wr(2, 'h80);
        tick('h10, 'h00, 'h15, 3);
        chk("R6 all masked first", flag, 1);
        clear_flag();
        tick('h11, 'h00, 'h15, 3);
        chk("R6 all masked again", flag, 1);

        // R7 write of 1 keeps flag, set beats clear
        wr(4, 1);
        chk("R7 write one no effect", flag, 1);
        clear_flag();
        tb_wr = 1; tb_addr = 3'd4; tb_wdata = 8'h00;
        tb_min = 8'h12; tb_tick = 1;
        cycle();
        tb_tick = 0; tb_wr = 0;
        chk("R7 set wins over clear", flag, 1);
        rd_check("R10 flag readback", 4, 1);
        clear_flag();
        rd_check("R10 flag readback clear", 4, 0);

        // R10 unused addresses
        wr(5, 'hff); wr(7, 'h00);
        rd_check("R10 addr5 reads zero", 5, 0);
        rd_check("R10 addr7 reads zero", 7, 0);
        rd_check("R10 minute reg untouched", 0, 'h80);
        rd_check("R10 weekday reg untouched", 3, 'h80);

        repeat (4) cycle();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule